// File: doc/BRIEF.md
# Grouped Pin Interrupt Combiner

This block folds a wide set of GPIO inputs into one interrupt line. The inputs are arranged as up to eight ports of equal width. For each pin, software sets two bits. An enable bit decides whether the pin takes part. A polarity bit decides whether a high level or a low level counts as active. The active, enabled pins are then merged by one of two rules: any pin active, or every enabled pin active. The merged condition drives a status bit, which is also the interrupt output. The status bit either latches on a rising transition of the condition (edge trigger) or follows the condition (level trigger).

Software reaches the block over a simple single-cycle register bus. A write strobe, a word address and write data go in, and the addressed register comes back combinationally on the read data. One control word holds the status bit, the combine rule and the trigger mode. Per-port polarity words and per-port enable words sit at fixed word addresses. Several instances can be placed side by side, each with its own pins and bus select.

Top module: `grp_irq_combiner`

## Requirements
- R1: Bit 0 of the control word (word address 0) reads 1 while a group request is pending and 0 otherwise, and the `irq` output always equals this bit.
- R2: In edge mode, writing the control word with bit 0 set clears the status bit. Writing bit 0 as 0 leaves the status bit unchanged.
- R3: Control bit 1 picks the combine rule. 0 means the condition is true when any enabled pin is active. 1 means it is true only when every enabled pin is active.
- R4: Control bit 2 picks the trigger. With 0 (edge), status is set on the clock edge after the condition goes from false to true, and then stays set until cleared. With 1 (level), status takes the condition's value on each clock edge, so it follows one cycle later.
- R5: A pin whose polarity bit is 1 is active when high. A pin whose polarity bit is 0 is active when low.
- R6: Pins whose enable bit is 0 have no effect on the condition. With the all-pins rule and no pin enabled, the condition is false.
- R7: After reset, the control, polarity and enable words all read 0, and `irq` is 0.
- R8: Bits 31 to 3 of the control word read as 0 whatever value was written to them.
- R9: In level mode, a clear write has no lasting effect while the condition is true: the status bit still reads 1 after the write.
- R10: The polarity word of port n is at word address 8+n, and the enable word of port n is at 16+n. Bit i of each word maps to pin n*PORT_W+i. Bits at and above PORT_W read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PORTS*PORT_W (64) | GPIO inputs; port n occupies bits n*PORT_W and up |
| irq | output | 1 | Group interrupt request |

## Verification
The bench first walks a table of enable, polarity and pin patterns under both combine rules. This catches a design that inverts the polarity sense, lets disabled pins leak into the condition, or raises the all-pins rule when no pin is enabled, which would give a spurious interrupt. Directed sequences then check the edge mode. The status must stay set after the pin drops, must ignore a write of zero, and must not set again while the condition stays high after a clear. A design that followed the level there, or treated the write as a plain store, would show the wrong `irq`. In level mode, a clear must not drop a held request. A pin on the highest port must reach the output, and the readback must keep reserved bits at zero.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

  typedef enum logic {CMB_ANY = 1'b0, CMB_ALL = 1'b1} cmb_mode_e;
  typedef enum logic {TRG_EDGE = 1'b0, TRG_LEVEL = 1'b1} trg_mode_e;

  localparam int unsigned CTRL_STAT_BIT = 0;
  localparam int unsigned CTRL_CMB_BIT  = 1;
  localparam int unsigned CTRL_TRG_BIT  = 2;

  // A pin is active when its level equals its polarity bit.
  function automatic logic pin_hit(input logic lvl, input logic pol);
    return ~(lvl ^ pol);
  endfunction

  // Next status value given the trigger mode and this cycle's events.
  function automatic logic next_status(input logic cur, input logic cond,
                                       input logic rise, input logic clr,
                                       input logic lvl_mode);
    if (lvl_mode) return cond;
    if (rise) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/grp_irq_regs.sv
module grp_irq_regs #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic                        status,
  output logic                        and_mode,
  output logic                        lvl_mode,
  output logic                        clr_pulse,
  output logic [NUM_PORTS*PORT_W-1:0] pol_flat,
  output logic [NUM_PORTS*PORT_W-1:0] en_flat
);
  import grp_irq_pkg::*;

  localparam int unsigned IDX_W    = ADDR_W - 2;
  localparam int unsigned POL_BASE = 1 << IDX_W;
  localparam int unsigned EN_BASE  = 2 << IDX_W;

  logic and_q, lvl_q;
  logic ctrl_sel;

  assign ctrl_sel  = (addr == '0);
  assign clr_pulse = wr && ctrl_sel && wdata[CTRL_STAT_BIT];
  assign and_mode  = and_q;
  assign lvl_mode  = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (wr && ctrl_sel) begin
      and_q <= wdata[CTRL_CMB_BIT];
      lvl_q <= wdata[CTRL_TRG_BIT];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] pol_q, en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol_q <= '0;
        en_q  <= '0;
      end else if (wr) begin
        if (addr == ADDR_W'(POL_BASE + p)) pol_q <= wdata[PORT_W-1:0];
        if (addr == ADDR_W'(EN_BASE + p))  en_q  <= wdata[PORT_W-1:0];
      end
    end
    assign pol_flat[p*PORT_W +: PORT_W] = pol_q;
    assign en_flat[p*PORT_W +: PORT_W]  = en_q;
  end

  always_comb begin
    rdata = '0;
    if (ctrl_sel) begin
      rdata[CTRL_STAT_BIT] = status;
      rdata[CTRL_CMB_BIT]  = and_q;
      rdata[CTRL_TRG_BIT]  = lvl_q;
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(POL_BASE + p)) rdata[PORT_W-1:0] = pol_flat[p*PORT_W +: PORT_W];
      if (addr == ADDR_W'(EN_BASE + p))  rdata[PORT_W-1:0] = en_flat[p*PORT_W +: PORT_W];
    end
  end

endmodule

// File: rtl/grp_irq_eval.sv
module grp_irq_eval #(
  parameter int unsigned NPINS = 64
) (
  input  logic [NPINS-1:0] pins,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] en,
  input  logic             and_mode,
  output logic             cond,
  output logic             en_any
);
  import grp_irq_pkg::*;

  logic [NPINS-1:0] hit;
  logic any_hit, all_hit;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign hit[i] = en[i] & pin_hit(pins[i], pol[i]);
  end

  assign en_any  = |en;
  assign any_hit = |hit;
  assign all_hit = (&(hit | ~en)) & en_any;
  assign cond    = and_mode ? all_hit : any_hit;

endmodule

// File: rtl/grp_irq_trig.sv
module grp_irq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic lvl_mode,
  input  logic clr_pulse,
  output logic cond_q,
  output logic rise,
  output logic status
);
  import grp_irq_pkg::*;

  assign rise = cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      status <= 1'b0;
    end else begin
      cond_q <= cond;
      status <= next_status(status, cond, rise, clr_pulse, lvl_mode);
    end
  end

endmodule

// File: rtl/grp_irq_combiner.sv
module grp_irq_combiner #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic                        irq
);
  localparam int unsigned NPINS = NUM_PORTS * PORT_W;

  logic             and_mode, lvl_mode, clr_pulse;
  logic             cond, en_any, cond_q, rise, status;
  logic [NPINS-1:0] pol_flat, en_flat;

  grp_irq_regs #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .status(status), .and_mode(and_mode), .lvl_mode(lvl_mode),
    .clr_pulse(clr_pulse), .pol_flat(pol_flat), .en_flat(en_flat)
  );

  grp_irq_eval #(.NPINS(NPINS)) u_eval (
    .pins(pin_in), .pol(pol_flat), .en(en_flat), .and_mode(and_mode),
    .cond(cond), .en_any(en_any)
  );

  grp_irq_trig u_trig (
    .clk(clk), .rst_n(rst_n), .cond(cond), .lvl_mode(lvl_mode),
    .clr_pulse(clr_pulse), .cond_q(cond_q), .rise(rise), .status(status)
  );

  assign irq = status;

endmodule

// File: rtl/grp_irq_checker.sv
module grp_irq_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cond,
  input logic              cond_q,
  input logic              en_any,
  input logic              and_mode,
  input logic              lvl_mode,
  input logic              clr_pulse,
  input logic              irq,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata
);

  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_mode |=> (irq == $past(cond)));

  p_edge_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && cond && !cond_q) |=> irq);

  p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && irq && !clr_pulse) |=> irq);

  p_edge_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && clr_pulse && !(cond && !cond_q)) |=> !irq);

  p_and_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (and_mode && !en_any) |-> !cond);

  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rdata[DATA_W-1:3] == '0));

  p_stat_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rdata[0] == irq));

endmodule

bind grp_irq_combiner grp_irq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond(cond), .cond_q(cond_q), .en_any(en_any),
  .and_mode(and_mode), .lvl_mode(lvl_mode), .clr_pulse(clr_pulse), .irq(irq),
  .addr(bus_addr), .rdata(bus_rdata)
);

// File: tb/grp_irq_combiner_bench.sv
`timescale 1ns/1ps
module grp_irq_combiner_bench;

  localparam int NP = 8;
  localparam int PW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP*PW-1:0] pin_in = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  grp_irq_combiner u_grp_irq_combiner (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq(irq)
  );

  // {and_rule, en0[7:0], pol0[7:0], pins0[7:0], expected}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'hFF, 8'hFF, 1'b0},
    {1'b0, 8'h01, 8'h01, 8'h01, 1'b1},
    {1'b0, 8'h01, 8'h00, 8'h01, 1'b0},
    {1'b0, 8'h0F, 8'h0F, 8'h00, 1'b0},
    {1'b0, 8'h0F, 8'h00, 8'h0E, 1'b1},
    {1'b1, 8'h0F, 8'h0F, 8'h0F, 1'b1},
    {1'b1, 8'h0F, 8'h0F, 8'h07, 1'b0},
    {1'b1, 8'h00, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hF0, 8'hA0, 8'hAF, 1'b1},
    {1'b1, 8'h81, 8'h80, 8'h80, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R7 reset state
    rd(5'd0, v);  check("R7 ctrl reset", v, 32'h0);
    rd(5'd8, v);  check("R7 pol0 reset", v, 32'h0);
    rd(5'd16, v); check("R7 en0 reset", v, 32'h0);
    check("R7 irq reset", {31'b0, irq}, 32'h0);

    // Table walk in level mode (R3 R5 R6)
    for (int i = 0; i < NV; i++) begin
      logic [25:0] e;
      e = VEC[i];
      wr(5'd0, {29'b0, 1'b1, e[25], 1'b0});
      wr(5'd16, {24'b0, e[24:17]});
      wr(5'd8, {24'b0, e[16:9]});
      pin_in = {{(NP-1)*PW{1'b1}}, e[8:1]};
      step();
      check($sformatf("R3/R5/R6 vector %0d irq", i), {31'b0, irq}, {31'b0, e[0]});
      rd(5'd0, v);
      check($sformatf("R1 vector %0d status", i), {31'b0, v[0]}, {31'b0, e[0]});
    end

    // Edge mode, OR rule, pin 0 active high
    wr(5'd16, 32'h1);
    wr(5'd8, 32'h1);
    pin_in = '0;
    step();
    wr(5'd0, 32'h0);
    step();
    check("R4 edge idle", {31'b0, irq}, 32'h0);
    pin_in[0] = 1'b1;
    step();
    check("R4 edge set", {31'b0, irq}, 32'h1);
    pin_in[0] = 1'b0;
    step(); step();
    check("R4 edge sticky", {31'b0, irq}, 32'h1);
    wr(5'd0, 32'h0);
    check("R2 write zero keeps", {31'b0, irq}, 32'h1);
    wr(5'd0, 32'h1);
    check("R2 w1c clears", {31'b0, irq}, 32'h0);
    rd(5'd0, v);
    check("R1 status after clear", v, 32'h0);
    pin_in[0] = 1'b1;
    step();
    check("R4 edge set again", {31'b0, irq}, 32'h1);
    wr(5'd0, 32'h1);
    step(); step();
    check("R4 no re-set while held", {31'b0, irq}, 32'h0);

    // Level mode, clear has no lasting effect (R9)
    wr(5'd0, 32'h4);
    step();
    check("R4 level follows", {31'b0, irq}, 32'h1);
    wr(5'd0, 32'h5);
    check("R9 level clear ignored", {31'b0, irq}, 32'h1);
    rd(5'd0, v);
    check("R9 ctrl readback", v, 32'h5);
    pin_in[0] = 1'b0;
    step();
    check("R4 level drops", {31'b0, irq}, 32'h0);

    // Highest port, active low (R10 R5)
    wr(5'd16, 32'h0);
    wr(5'd23, 32'h08);
    wr(5'd15, 32'h00);
    pin_in = '1;
    pin_in[7*PW+3] = 1'b0;
    step();
    check("R10 port7 pin active", {31'b0, irq}, 32'h1);
    pin_in[7*PW+3] = 1'b1;
    step();
    check("R10 port7 pin idle", {31'b0, irq}, 32'h0);
    rd(5'd23, v); check("R10 en7 readback", v, 32'h08);
    wr(5'd8, 32'hFFFF_FFFF);
    rd(5'd8, v);  check("R10 pol0 width", v, 32'h0000_00FF);

    // Reserved bits (R8)
    wr(5'd0, 32'hFFFF_FFFE);
    step();
    rd(5'd0, v);
    check("R8 reserved zero", v, 32'h6);

    // All-pins rule with nothing enabled (R6)
    wr(5'd23, 32'h0);
    pin_in = '0;
    step();
    check("R6 and-empty quiet", {31'b0, irq}, 32'h0);

    done = 1;
    finish_run();
  end

endmodule